// File: doc/BRIEF.md
# Serial Command Shift Front-End

This block is the receive and forward stage of a three-wire serial port. It sits in front of a command decoder for a two-channel converter control core. A host lowers chip-select and clocks a 16-bit command in on the data pin, most significant bit first. When chip-select returns high, the finished word goes to the decoder together with a single-cycle valid strobe. A frame with the wrong length, or a word whose last bit is set, raises an error pulse instead of the strobe.

The three pad inputs are sampled through two-stage synchronisers on a fast system clock. Edges are found by comparing consecutive synchronised samples. While chip-select is low, the serial output shows the most significant bit of the shift register, so several devices can be chained. The decoder supplies a mode bit that picks the serial clock edge on which this output moves. That bit is captured each time chip-select falls.

Top module: `serial_cmd_frontend`

## Requirements
- R1: The first bit received in a frame lands in `word_o[15]` and the last one in `word_o[0]`. The control field therefore occupies bits 15..13, the data field bits 12..1, and the sub-bit bit 0.
- R2: A bit is taken from the data pin only on a synchronised rising edge of the serial clock while chip-select is low.
- R3: While chip-select is high, serial clock and data pin activity leave the shift register unchanged and produce no strobe or error pulse.
- R4: Three system-clock edges after chip-select rises at the pin, `word_valid_o` pulses for exactly one cycle. This happens only if exactly 16 bits were shifted in and bit 0 is 0. `word_o` changes only together with that pulse and holds its value otherwise.
- R5: A word sent as two 8-bit bursts, with a pause between them and chip-select held low, gives the same result as one 16-bit burst.
- R6: If chip-select rises after any bit count other than 16, including zero, `frame_err_o` pulses for one cycle and `word_valid_o` stays low. The shift register keeps the last 16 bits shifted in.
- R7: If exactly 16 bits arrived and bit 0 is 1, `subbit_err_o` pulses for one cycle, no strobe is given, and `word_o` is unchanged.
- R8: In mode 0 (`dout_mode_i` = 0), `dout_o` takes the shift register MSB on each falling serial clock edge. At chip-select fall it takes the MSB held at that moment.
- R9: In mode 1, `dout_o` changes on each rising serial clock edge to the MSB of the register after that edge's shift.
- R10: `dout_mode_i` is captured at chip-select fall. A change during a frame takes effect only from the next frame.
- R11: After reset, `word_o` is 0, all pulses are low, `dout_o` is 0, and the mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pad, asynchronous |
| cs_n_i | input | 1 | Chip-select pad, active low, asynchronous |
| din_i | input | 1 | Serial data pad, asynchronous |
| dout_mode_i | input | 1 | Output edge select from the decoder: 0 falling, 1 rising |
| dout_o | output | 1 | Serial data output for chaining |
| word_o | output | 16 | Last accepted command word |
| word_valid_o | output | 1 | One-cycle strobe for an accepted word |
| frame_err_o | output | 1 | One-cycle pulse for a frame with a bit count other than 16 |
| subbit_err_o | output | 1 | One-cycle pulse for a 16-bit word with bit 0 set |

## Verification
A wrong bit counter shows up exactly three system clocks after chip-select rises, as a missing strobe or a spurious error pulse. A wrong shift register shows up either as a bad `word_o` at that strobe or, one frame later, as wrong bits on `dout_o` while the next frame clocks out. A wrong captured mode moves `dout_o` half a serial period early or late. The bench sees this on the first bit of the frame by sampling just before each falling edge.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int WORD_W      = 16;
    localparam int SYNC_STAGES = 2;
    localparam int CNT_W       = $clog2(WORD_W + 2);
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sc_shifter.sv
module sc_shifter #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low_i,
    input  logic              cs_fall_i,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              din_i,
    input  logic              mode_i,
    output logic [WORD_W-1:0] shreg_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              dout_o
);
    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              mode;
        logic              dout;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_fall_i) begin
            st_d.cnt  = '0;
            st_d.mode = mode_i;
            st_d.dout = st_q.sh[WORD_W-1];
        end else if (cs_low_i) begin
            if (sclk_rise_i) begin
                st_d.sh = {st_q.sh[WORD_W-2:0], din_i};
                if (st_q.cnt != CNT_CAP) st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.mode) st_d.dout = st_q.sh[WORD_W-2];
            end else if (sclk_fall_i && !st_q.mode) begin
                st_d.dout = st_q.sh[WORD_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shreg_o = st_q.sh;
    assign count_o = st_q.cnt;
    assign dout_o  = st_q.dout;

    // R3
    cs_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low_i |=> $stable(st_q.sh));
    // R2
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise_i |=> $stable(st_q.sh));
    // R8
    mode0_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.mode && !sclk_fall_i && !cs_fall_i) |=> $stable(st_q.dout));
    // R9
    mode1_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode && !sclk_rise_i && !cs_fall_i) |=> $stable(st_q.dout));
    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall_i |=> $stable(st_q.mode));
endmodule

// File: rtl/sc_frame_ctl.sv
module sc_frame_ctl #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise_i,
    input  logic [WORD_W-1:0] shreg_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              ferr_o,
    output logic              serr_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              ferr;
        logic              serr;
    } frm_t;

    frm_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.ferr  = 1'b0;
        st_d.serr  = 1'b0;
        if (cs_rise_i) begin
            if (count_i != FULL) begin
                st_d.ferr = 1'b1;
            end else if (shreg_i[0]) begin
                st_d.serr = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.word  = shreg_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;
    assign ferr_o  = st_q.ferr;
    assign serr_o  = st_q.serr;

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);
    // R4
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.word) |-> st_q.valid);
    // R6
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.valid, st_q.ferr, st_q.serr}));
    // R7
    serr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.serr |=> !st_q.serr);
endmodule

// File: rtl/serial_cmd_frontend.sv
module serial_cmd_frontend
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              din_i,
    input  logic              dout_mode_i,
    output logic              dout_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              frame_err_o,
    output logic              subbit_err_o
);
    typedef struct packed {
        logic cs_n;
        logic sclk;
    } prev_t;

    logic [2:0]        pads_s;
    logic              cs_n_s, sclk_s, din_s;
    prev_t             prv_d, prv_q;
    logic              cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  count;

    sc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, sclk_i, din_i}),
        .q_o   (pads_s)
    );

    assign cs_n_s = pads_s[2];
    assign sclk_s = pads_s[1];
    assign din_s  = pads_s[0];

    always_comb begin
        prv_d.cs_n = cs_n_s;
        prv_d.sclk = sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prv_q <= '{cs_n: 1'b1, sclk: 1'b0};
        else        prv_q <= prv_d;
    end

    assign cs_fall   =  prv_q.cs_n & ~cs_n_s;
    assign cs_rise   = ~prv_q.cs_n &  cs_n_s;
    assign sclk_rise = ~prv_q.sclk &  sclk_s;
    assign sclk_fall =  prv_q.sclk & ~sclk_s;

    sc_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_low_i    (~cs_n_s),
        .cs_fall_i   (cs_fall),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .din_i       (din_s),
        .mode_i      (dout_mode_i),
        .shreg_o     (shreg),
        .count_o     (count),
        .dout_o      (dout_o)
    );

    sc_frame_ctl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_rise_i (cs_rise),
        .shreg_i   (shreg),
        .count_i   (count),
        .word_o    (word_o),
        .valid_o   (word_valid_o),
        .ferr_o    (frame_err_o),
        .serr_o    (subbit_err_o)
    );

    // R4
    strobe_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> $past(cs_rise));
    // R3
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && prv_q.cs_n) |=> !(word_valid_o || frame_err_o || subbit_err_o));
endmodule

// File: tb/serial_cmd_frontend_bench.sv
module serial_cmd_frontend_bench;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, din = 1'b0, mode = 1'b0;
    logic        dout, valid, ferr, serr;
    logic [15:0] word;

    int          n_chk = 0, n_bad = 0;
    logic [15:0] model_sh = '0, last_word = '0;
    bit          done = 0;

    always #10 clk = ~clk;

    serial_cmd_frontend u_serial_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
        .dout_mode_i(mode), .dout_o(dout), .word_o(word),
        .word_valid_o(valid), .frame_err_o(ferr), .subbit_err_o(serr)
    );

    typedef struct packed {
        logic [5:0]  n;
        logic [31:0] bits;
        logic        split;
        logic        md;
        logic        ev;
        logic        ef;
        logic        es;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{6'd16, 32'h0000_3A5C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{6'd16, 32'h0000_C7F2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{6'd16, 32'h0000_8001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{6'd12, 32'h0000_0ABC, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{6'd20, 32'h0005_9E3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{6'd16, 32'h0000_FFFE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{6'd16, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{6'd0,  32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic run_frame(int n, logic [31:0] bits, bit split, bit md, bit flip,
                             bit ev, bit ef, bit es);
        int       dbad = 0, seen = 0, idx = 0;
        logic [2:0] flags = '0;
        logic [2:0] expf;
        mode = md;
        wait_n(2);
        cs_n = 1'b0;
        wait_n(8);
        for (int i = n - 1; i >= 0; i--) begin
            logic b, e0, e1;
            b  = bits[i];
            din = b;
            e0 = model_sh[15];
            model_sh = {model_sh[14:0], b};
            e1 = model_sh[15];
            wait_n(8);
            sclk = 1'b1;
            wait_n(7);
            if (dout !== (md ? e1 : e0)) dbad++;
            wait_n(1);
            sclk = 1'b0;
            wait_n(8);
            if (split && i == n - 8) wait_n(40);
            if (flip && i == n - 4) mode = ~md;
        end
        wait_n(8);
        cs_n = 1'b1;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (valid || ferr || serr) begin
                if (seen == 0) begin
                    idx   = c;
                    flags = {valid, ferr, serr};
                end
                seen++;
            end
        end
        expf = {ev, ef, es};
        if (ev) last_word = bits[15:0];
        // R4 strobe / R6 frame error / R7 sub-bit error, timing three clocks after chip-select rise
        chk(flags == expf && seen == 1 && idx == 3, "R4/R6/R7 pulse flags and timing",
            {flags, 8'(seen), 8'(idx)}, {expf, 8'd1, 8'd3});
        // R1 bit order, R2 capture, R5 split bursts give the same word
        chk(word == last_word, "R1/R2/R5 word_o", 32'(word), 32'(last_word));
        // R8 falling-edge output in mode 0, R9 rising-edge output in mode 1, R10 latched mode
        chk(dbad == 0, md ? "R9/R10 dout in mode 1" : "R8/R10 dout in mode 0",
            32'(dbad), 32'd0);
        wait_n(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int pulses;
        wait_n(3);
        // R11 reset state, sampled while reset is held and just after release
        chk(word == 16'h0 && !valid && !ferr && !serr && dout == 1'b0, "R11 reset outputs",
            {word, 13'h0, valid, ferr, serr}, 32'h0);
        rst_n = 1'b1;
        wait_n(6);
        chk(word == 16'h0 && !valid && !ferr && !serr && dout == 1'b0, "R11 after release",
            {word, 13'h0, valid, ferr, serr}, 32'h0);

        for (int v = 0; v < 8; v++) begin
            run_frame(int'(VECS[v].n), VECS[v].bits, VECS[v].split, VECS[v].md, 1'b0,
                      VECS[v].ev, VECS[v].ef, VECS[v].es);
        end

        // R3: serial clock and data toggle with chip-select high
        pulses = 0;
        for (int t = 0; t < 12; t++) begin
            din  = ~din;
            sclk = 1'b1;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (valid || ferr || serr) pulses++;
            end
            sclk = 1'b0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (valid || ferr || serr) pulses++;
            end
        end
        chk(pulses == 0, "R3 no pulse while deselected", 32'(pulses), 32'd0);
        // the next frame's dout shows the register untouched by the ignored toggles (R3)
        run_frame(16, 32'h0000_5A5A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        // R10: mode request flipped mid-frame, the latched mode stays in force
        run_frame(16, 32'h0000_9C3E, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_frame(16, 32'h0000_6B14, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

        // R6: an over-long frame keeps the last 16 bits, seen on dout in the next frame
        run_frame(18, 32'h0003_A7C2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        run_frame(16, 32'h0000_1234, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule